// File: doc/BRIEF.md
# Residue-Domain Shift-Add FIR Decimator

This block is a second-level wavelet filter stage that works entirely in a three-channel residue number system. The moduli are 2^n−1, 2^n and 2^(n+1)−1. Residue samples arrive straight from the previous filter level and are never converted back to binary on the way through. Each channel keeps its own short delay line of past samples.

Each channel multiplies every delayed sample by a fixed coefficient. The coefficient is written as a small sum of signed powers of two. Multiplying by a power of two costs only wiring. In the two 2^k−1 channels it is a left rotation, and in the 2^n channel it is a left shift that drops the bits pushed off the top.

A negative term is applied by adding its modular complement. The term products are summed with modular adders, first within a tap and then across taps. The stage keeps every second accepted sample's result, so it decimates by two, and marks each result with a one-cycle valid pulse.

The block has no look-up table, no multiplier and no carry path between channels. The coefficient set is an elaboration-time parameter. A final residue-to-binary conversion, where one is needed, belongs to a later block.

Top module: `rfir_stage`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `out_valid` is 0 and all three output residues are 0. Reset also clears the delay lines and the decimation phase, so samples from before reset do not contribute to later outputs.
- R2: `out_valid` rises for exactly one cycle, on the clock edge that accepts the 2nd, 4th, 6th, ... sample counted since reset. It is never high on two consecutive cycles.
- R3: When `out_valid` is high, each output residue equals (Σ c_k · x[j−k]) mod m for that channel's modulus m. Here x[j] is the sample accepted on that edge, k runs over 0..3, and samples from before the first accepted sample count as 0. The default coefficients are c = 7, 20, −4, −30.
- R4: Coefficient term encoding is one byte per term: bit 7 enables the term, bit 6 negates it, and bits 5..0 hold the power of two. Term j of tap k sits at byte k·N_TERMS+j of `TERM_CFG`.
- R5: The three channels are independent. Each output residue depends only on the samples of its own channel.
- R6: When `in_valid` is 0, the sample inputs are ignored. They enter no delay line, they do not advance the decimation phase, and they produce no output.
- R7: In the 2^n−1 and 2^(n+1)−1 channels, an all-ones input is accepted as a second code for zero. An all-ones value never appears on those outputs; zero is always reported as 0.
- R8: Between valid pulses, the output residues hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Accept the residue sample on this edge |
| in_res_lo | input | BASE_N | Sample residue mod 2^n−1 |
| in_res_pw | input | BASE_N | Sample residue mod 2^n |
| in_res_hi | input | BASE_N+1 | Sample residue mod 2^(n+1)−1 |
| out_valid | output | 1 | One-cycle pulse, result available |
| out_res_lo | output | BASE_N | Filtered residue mod 2^n−1 |
| out_res_pw | output | BASE_N | Filtered residue mod 2^n |
| out_res_hi | output | BASE_N+1 | Filtered residue mod 2^(n+1)−1 |

## Verification
The stimulus includes maximum residues and all-ones codes on the 2^k−1 channels. A design with a broken end-around carry would report values off by one, or would emit 127 or 255 where 0 belongs. The two negative coefficients exercise the complement path. A design that complemented the 2^n channel without the +1, or that rotated instead of shifting there, would miss the expected residue.

Idle gaps are inserted with garbage on the inputs, once at each decimation phase. A design that let an unaccepted sample shift in, or that advanced the phase on it, would produce an output on the wrong sample or corrupt a later result. A reset in the middle of a stream is followed by two fresh samples. Stale history left in the delay line would show up in the first output after that reset.

// File: rtl/rfir_pkg.sv
package rfir_pkg;

   // Channel flavour: modulus 2^W-1 (end-around carry) or 2^W (carry dropped)
   typedef enum logic [0:0] {
      MOD_PM1 = 1'b0,
      MOD_P2  = 1'b1
   } mod_kind_e;

   localparam int TERM_BITS = 8;

   function automatic logic term_en(input logic [TERM_BITS-1:0] cfg);
      return cfg[7];
   endfunction

   function automatic logic term_neg(input logic [TERM_BITS-1:0] cfg);
      return cfg[6];
   endfunction

   function automatic int term_shift(input logic [TERM_BITS-1:0] cfg);
      return int'(cfg[5:0]);
   endfunction

endpackage

// File: rtl/rfir_madd.sv
module rfir_madd #(
   parameter int                 W    = 7,
   parameter rfir_pkg::mod_kind_e KIND = rfir_pkg::MOD_PM1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] s
);
   generate
      if (W < 2) begin : g_bad_w
         $error("rfir_madd: W must be at least 2");
      end

      if (KIND == rfir_pkg::MOD_P2) begin : g_pow2
         // carry out of the top bit is simply lost
         assign s = a + b;
      end else begin : g_pm1
         logic [W:0]   wide;
         logic [W-1:0] folded;
         assign wide   = {1'b0, a} + {1'b0, b};
         // end-around carry cannot overflow: with carry set, low part <= 2^W-2
         assign folded = wide[W-1:0] + {{(W-1){1'b0}}, wide[W]};
         // all-ones is the redundant code for zero
         assign s      = (&folded) ? '0 : folded;
      end
   endgenerate
endmodule

// File: rtl/rfir_pow2.sv
module rfir_pow2 #(
   parameter int                 W    = 7,
   parameter rfir_pkg::mod_kind_e KIND = rfir_pkg::MOD_PM1,
   parameter int                 SH   = 0,
   parameter bit                 NEG  = 1'b0
) (
   input  logic [W-1:0] x,
   output logic [W-1:0] y
);
   localparam int ROT = SH % W;

   logic [W-1:0] scaled;

   generate
      if (SH < 0 || SH > 63) begin : g_bad_sh
         $error("rfir_pow2: shift out of encodable range");
      end

      if (KIND == rfir_pkg::MOD_PM1) begin : g_rot
         // 2^W = 1 mod 2^W-1, so scaling is a rotation
         if (ROT == 0) begin : g_r0
            assign scaled = x;
         end else begin : g_rn
            assign scaled = {x[W-1-ROT:0], x[W-1:W-ROT]};
         end
         if (NEG) begin : g_neg
            assign y = ~scaled;
         end else begin : g_pos
            assign y = scaled;
         end
      end else begin : g_shl
         if (SH >= W) begin : g_zero
            logic unused_x;
            assign unused_x = ^x;
            assign scaled   = '0;
         end else begin : g_move
            assign scaled = x << SH;
         end
         if (NEG) begin : g_neg
            assign y = ~scaled + {{(W-1){1'b0}}, 1'b1};
         end else begin : g_pos
            assign y = scaled;
         end
      end
   endgenerate
endmodule

// File: rtl/rfir_chan.sv
module rfir_chan #(
   parameter int                 W        = 7,
   parameter rfir_pkg::mod_kind_e KIND     = rfir_pkg::MOD_PM1,
   parameter int                 N_TAPS   = 4,
   parameter int                 N_TERMS  = 2,
   parameter logic [N_TAPS*N_TERMS*rfir_pkg::TERM_BITS-1:0] TERM_CFG = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         emit,
   input  logic [W-1:0] x_in,
   output logic [W-1:0] y_out
);
   import rfir_pkg::*;

   localparam int N_DLY = N_TAPS - 1;

   logic [W-1:0] dly    [N_DLY];
   logic [W-1:0] tap_in [N_TAPS];
   logic [W-1:0] term   [N_TAPS][N_TERMS];
   logic [W-1:0] part   [N_TAPS][N_TERMS];
   logic [W-1:0] acc    [N_TAPS];

   // delay line: moves only on an accepted sample
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_DLY; i++) dly[i] <= '0;
      end else if (shift_en) begin
         dly[0] <= x_in;
         for (int i = 1; i < N_DLY; i++) dly[i] <= dly[i-1];
      end
   end

   assign tap_in[0] = x_in;

   genvar k, j;
   generate
      for (k = 1; k < N_TAPS; k++) begin : g_tin
         assign tap_in[k] = dly[k-1];
      end

      for (k = 0; k < N_TAPS; k++) begin : g_tap
         for (j = 0; j < N_TERMS; j++) begin : g_term
            localparam logic [TERM_BITS-1:0] CFG =
               TERM_CFG[(k*N_TERMS+j)*TERM_BITS +: TERM_BITS];
            if (term_en(CFG)) begin : g_on
               rfir_pow2 #(
                  .W(W), .KIND(KIND),
                  .SH(term_shift(CFG)), .NEG(term_neg(CFG))
               ) u_pow2 (
                  .x(tap_in[k]),
                  .y(term[k][j])
               );
            end else begin : g_off
               assign term[k][j] = '0;
            end

            if (j == 0) begin : g_first
               assign part[k][0] = term[k][0];
            end else begin : g_sum
               rfir_madd #(.W(W), .KIND(KIND)) u_tadd (
                  .a(part[k][j-1]),
                  .b(term[k][j]),
                  .s(part[k][j])
               );
            end
         end

         if (k == 0) begin : g_acc0
            assign acc[0] = part[0][N_TERMS-1];
         end else begin : g_accn
            rfir_madd #(.W(W), .KIND(KIND)) u_xadd (
               .a(acc[k-1]),
               .b(part[k][N_TERMS-1]),
               .s(acc[k])
            );
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) y_out <= '0;
      else if (shift_en && emit) y_out <= acc[N_TAPS-1];
   end

   AST_DLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(dly[0])); // R6

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(shift_en && emit) |=> $stable(y_out)); // R8

   generate
      if (KIND == MOD_PM1) begin : g_canon
         AST_OUT_CANON: assert property (@(posedge clk) disable iff (!rst_n)
            !(&y_out)); // R7
      end
   endgenerate
endmodule

// File: rtl/rfir_stage.sv
module rfir_stage #(
   parameter int BASE_N  = 7,
   parameter int N_TAPS  = 4,
   parameter int N_TERMS = 2,
   // per tap: {+2^3,-2^0}, {+2^4,+2^2}, {-2^2,off}, {+2^1,-2^5}
   parameter logic [N_TAPS*N_TERMS*rfir_pkg::TERM_BITS-1:0] TERM_CFG =
      64'hC5_81_00_C2_82_84_C0_83
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BASE_N-1:0] in_res_lo,
   input  logic [BASE_N-1:0] in_res_pw,
   input  logic [BASE_N:0]   in_res_hi,
   output logic              out_valid,
   output logic [BASE_N-1:0] out_res_lo,
   output logic [BASE_N-1:0] out_res_pw,
   output logic [BASE_N:0]   out_res_hi
);
   import rfir_pkg::*;

   localparam int W_LO = BASE_N;
   localparam int W_HI = BASE_N + 1;

   generate
      if (BASE_N < 2 || BASE_N > 30) begin : g_bad_n
         $error("rfir_stage: BASE_N out of range");
      end
      if (N_TAPS < 2) begin : g_bad_taps
         $error("rfir_stage: need at least two taps");
      end
      if (N_TERMS < 1) begin : g_bad_terms
         $error("rfir_stage: need at least one term per tap");
      end
   endgenerate

   logic phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid && phase;
         if (in_valid) phase <= ~phase;
      end
   end

   rfir_chan #(
      .W(W_LO), .KIND(MOD_PM1), .N_TAPS(N_TAPS), .N_TERMS(N_TERMS), .TERM_CFG(TERM_CFG)
   ) u_lo (
      .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .emit(phase),
      .x_in(in_res_lo), .y_out(out_res_lo)
   );

   rfir_chan #(
      .W(W_LO), .KIND(MOD_P2), .N_TAPS(N_TAPS), .N_TERMS(N_TERMS), .TERM_CFG(TERM_CFG)
   ) u_pw (
      .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .emit(phase),
      .x_in(in_res_pw), .y_out(out_res_pw)
   );

   rfir_chan #(
      .W(W_HI), .KIND(MOD_PM1), .N_TAPS(N_TAPS), .N_TERMS(N_TERMS), .TERM_CFG(TERM_CFG)
   ) u_hi (
      .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .emit(phase),
      .x_in(in_res_hi), .y_out(out_res_hi)
   );

   AST_VALID_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid); // R2

   AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid)); // R2

   AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid); // R6
endmodule

// File: tb/tb_rfir_stage.sv
module tb_rfir_stage;
   localparam int CLK_PERIOD = 10;
   localparam int M_LO = 127;
   localparam int M_PW = 128;
   localparam int M_HI = 255;
   localparam int NS   = 12;

   // stimulus table: {lo, pw, hi}; all-ones codes 127/255 included (R7)
   localparam int STIM [NS][3] = '{
      '{5, 3, 9},     '{126, 127, 254}, '{0, 0, 0},     '{64, 100, 200},
      '{1, 1, 1},     '{127, 64, 255},  '{33, 77, 128}, '{100, 12, 17},
      '{126, 0, 254}, '{2, 127, 3},     '{90, 45, 180}, '{127, 127, 255}
   };
   // coefficients implied by the default term bytes (R4)
   localparam int COEF [4] = '{7, 20, -4, -30};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [6:0] in_res_lo = '0;
   logic [6:0] in_res_pw = '0;
   logic [7:0] in_res_hi = '0;
   logic       out_valid;
   logic [6:0] out_res_lo;
   logic [6:0] out_res_pw;
   logic [7:0] out_res_hi;

   rfir_stage dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .in_res_lo(in_res_lo), .in_res_pw(in_res_pw), .in_res_hi(in_res_hi),
      .out_valid(out_valid),
      .out_res_lo(out_res_lo), .out_res_pw(out_res_pw), .out_res_hi(out_res_hi)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   int h_lo [64];
   int h_pw [64];
   int h_hi [64];
   int cnt = 0;
   int l_lo = 0, l_pw = 0, l_hi = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int conv(input int ch, input int m);
      longint s = 0;
      for (int k = 0; k < 4; k++) begin
         int idx = cnt - 1 - k;
         if (idx >= 0) begin
            int v = (ch == 0) ? h_lo[idx] : (ch == 1) ? h_pw[idx] : h_hi[idx];
            s += longint'(COEF[k]) * longint'(v);
         end
      end
      s = s % m;
      if (s < 0) s += m;
      return int'(s);
   endfunction

   // called at a negedge; returns at the following negedge
   task automatic push(input int a, input int b, input int c);
      bit emit = (cnt % 2) == 1;
      h_lo[cnt] = a; h_pw[cnt] = b; h_hi[cnt] = c;
      cnt++;
      in_valid  = 1'b1;
      in_res_lo = 7'(a); in_res_pw = 7'(b); in_res_hi = 8'(c);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R2", "out_valid", int'(out_valid), int'(emit));
      if (emit) begin
         l_lo = conv(0, M_LO); l_pw = conv(1, M_PW); l_hi = conv(2, M_HI);
         chk("R3", "lo residue", int'(out_res_lo), l_lo);
         chk("R5", "pow2 residue", int'(out_res_pw), l_pw);
         chk("R3", "hi residue", int'(out_res_hi), l_hi);
         chk("R7", "lo never all-ones", int'(&out_res_lo), 0);
      end else begin
         chk("R8", "lo held", int'(out_res_lo), l_lo);
         chk("R8", "hi held", int'(out_res_hi), l_hi);
      end
   endtask

   task automatic idle(input int cycles, input int a, input int b, input int c);
      in_valid  = 1'b0;
      in_res_lo = 7'(a); in_res_pw = 7'(b); in_res_hi = 8'(c);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         chk("R6", "no pulse when idle", int'(out_valid), 0);
         chk("R6", "lo unchanged", int'(out_res_lo), l_lo);
         chk("R6", "pow2 unchanged", int'(out_res_pw), l_pw);
         chk("R6", "hi unchanged", int'(out_res_hi), l_hi);
      end
   endtask

   task automatic check_clear(input string tag);
      chk("R1", {tag, " out_valid"}, int'(out_valid), 0);
      chk("R1", {tag, " lo"}, int'(out_res_lo), 0);
      chk("R1", {tag, " pow2"}, int'(out_res_pw), 0);
      chk("R1", {tag, " hi"}, int'(out_res_hi), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_clear("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_clear("after reset");

      // table walk: main function under varied patterns (R3, R5, R7)
      for (int i = 0; i < NS; i++) push(STIM[i][0], STIM[i][1], STIM[i][2]);

      // idle with garbage at phase 0, then at phase 1 (R6)
      idle(3, 77, 55, 99);
      push(10, 20, 30);
      idle(2, 127, 127, 255);
      push(127, 127, 255);

      // reset in mid-stream clears history and phase (R1)
      push(3, 4, 5);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      cnt = 0; l_lo = 0; l_pw = 0; l_hi = 0;
      check_clear("mid-stream");
      push(1, 2, 3);
      push(4, 5, 6);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule